// File: doc/BRIEF.md
# Software-Posted Interrupt Request Register

This block is a 16-bit memory-mapped register through which software posts interrupt requests at any of seven priority levels, 1 to 7. Each level owns one writable request bit in the upper part of the word. The block continuously encodes the highest pending level. It mirrors that level into two read-only 3-bit fields of the same word, so a service routine can read it from either field.

The encoded level is compared against the processor's current priority. When it is strictly greater, the block offers an interrupt on a valid/ready style output. The offer carries the level and a fixed vector shared by all seven sources. The processor accepts the offer by raising the acknowledge input while valid is high. After the accepting cycle, valid drops for one cycle, and it re-asserts only if a qualifying request is still posted. Acknowledge never clears a request bit. The service routine must clear its own bit by writing it to zero, or the same level is offered again once priority allows.

Top module: `swi_pirq_top`

## Requirements
- R1: Reset clears all seven request bits, so the register reads zero and no interrupt is offered.
- R2: A write sets request bits 15 down to 9 for levels 7 down to 1 (bit 9 + L - 1 is level L), and the new bits read back in the cycle after the write edge.
- R3: Read bits 7:5 and read bits 3:1 both hold the highest requested level as an unsigned 3-bit number, or 0 when no request bit is set.
- R4: Read bits 8, 4 and 0 are always zero, and write data in bits 8:0 has no effect on any request bit.
- R5: `irq_valid` is registered: it is high in a cycle only if, at the previous edge, the highest pending level was strictly greater than `cur_pri` (a level equal to the priority is not offered).
- R6: While `irq_valid` is high, `irq_level` equals the highest pending level seen at the previous edge, and `irq_vector` always reads 240 octal (0xA0).
- R7: An edge with `irq_valid` and `irq_ack` both high is one transfer: `irq_valid` is low in the next cycle, and the acknowledge leaves every request bit unchanged.
- R8: Writing the highest request bit to zero while lower bits remain makes both level fields drop to the next lower pending level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (request bits and level fields) |
| cur_pri | input | 3 | Current processor priority, 0 to 7 |
| irq_valid | output | 1 | Interrupt offered to the processor |
| irq_level | output | 3 | Priority level of the offered interrupt |
| irq_vector | output | 9 | Vector of the offered interrupt, 240 octal |
| irq_ack | input | 1 | Processor accepts the offered interrupt (ready) |

## Verification
Single-bit posts at each level against priorities just below, equal to and above that level show the strict comparison and the level encoding. Several bits posted together show that the highest bit wins the encoding in both mirrored fields. Writes carrying noise in the low byte show that the level fields and unused bits ignore write data. Acknowledges with and without a pending offer show the one-cycle gap after a transfer and that no request bit is cleared. A long random mix of writes, priorities and acknowledges is compared each cycle against a bench model of the register and the offer.

// File: rtl/swi_pirq_pkg.sv
package swi_pirq_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = 3;
  localparam int REQ_LSB = DATA_W - NUM_LVL;  // request bits 15:9
  localparam int HI_FLD  = 5;                 // mirrored level, bits 7:5
  localparam int LO_FLD  = 1;                 // mirrored level, bits 3:1
  localparam int VEC_W   = 9;
  localparam logic [VEC_W-1:0] SHARED_VEC = 9'o240;

  typedef logic [NUM_LVL-1:0] req_vec_t;
  typedef logic [LVL_W-1:0]   level_t;
endpackage

// File: rtl/swi_pirq_store.sv
module swi_pirq_store
  import swi_pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output req_vec_t          req_q
);
  // Only the request slice of the write word is stored; the rest is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n)
      req_q <= '0;
    else if (wr_en)
      req_q <= wr_data[REQ_LSB +: NUM_LVL];
  end
endmodule

// File: rtl/swi_pirq_enc.sv
module swi_pirq_enc
  import swi_pirq_pkg::*;
(
  input  req_vec_t req,
  output level_t   top_lvl
);
  // Ripple chain from level 1 upward; a higher set bit overrides lower ones.
  level_t chain [NUM_LVL+1];
  assign chain[0] = '0;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_stage
    assign chain[g+1] = req[g] ? level_t'(g + 1) : chain[g];
  end

  assign top_lvl = chain[NUM_LVL];
endmodule

// File: rtl/swi_pirq_deliver.sv
module swi_pirq_deliver
  import swi_pirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  level_t   top_lvl,
  input  level_t   cur_pri,
  input  logic     ack,
  output logic     valid_q,
  output level_t   level_q
);
  logic want;
  logic taken;

  assign want  = top_lvl > cur_pri;
  assign taken = valid_q && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      level_q <= '0;
    end else begin
      valid_q <= want && !taken;
      level_q <= top_lvl;
    end
  end
endmodule

// File: rtl/swi_pirq_top.sv
module swi_pirq_top
  import swi_pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  cur_pri,
  output logic              irq_valid,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack
);
  req_vec_t req_q;
  level_t   top_lvl;

  swi_pirq_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req_q   (req_q)
  );

  swi_pirq_enc u_enc (
    .req     (req_q),
    .top_lvl (top_lvl)
  );

  swi_pirq_deliver u_dlv (
    .clk     (clk),
    .rst_n   (rst_n),
    .top_lvl (top_lvl),
    .cur_pri (cur_pri),
    .ack     (irq_ack),
    .valid_q (irq_valid),
    .level_q (irq_level)
  );

  // Read word: request bits, then two copies of the level; gaps read zero.
  always_comb begin
    rd_data = '0;
    rd_data[REQ_LSB +: NUM_LVL] = req_q;
    rd_data[HI_FLD +: LVL_W]    = top_lvl;
    rd_data[LO_FLD +: LVL_W]    = top_lvl;
  end

  assign irq_vector = SHARED_VEC;
endmodule

// File: rtl/swi_pirq_chk.sv
module swi_pirq_chk
  import swi_pirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [LVL_W-1:0]  cur_pri,
  input logic              irq_valid,
  input logic [LVL_W-1:0]  irq_level,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              irq_ack
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0) && !irq_valid);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[REQ_LSB +: NUM_LVL] == $past(wr_data[REQ_LSB +: NUM_LVL]));

  a_r3_fields_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[HI_FLD +: LVL_W] == rd_data[LO_FLD +: LVL_W]);

  a_r4_gaps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[8] && !rd_data[4] && !rd_data[0]);

  a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level > $past(cur_pri));

  a_r6_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == SHARED_VEC);

  a_r7_gap_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);

  a_r7_ack_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !wr_en |=> $stable(rd_data[REQ_LSB +: NUM_LVL]));
endmodule

bind swi_pirq_top swi_pirq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .cur_pri    (cur_pri),
  .irq_valid  (irq_valid),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .irq_ack    (irq_ack)
);

// File: tb/sim_swi_pirq_top.sv
module sim_swi_pirq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [2:0]  cur_pri;
  logic        irq_valid;
  logic [2:0]  irq_level;
  logic [8:0]  irq_vector;
  logic        irq_ack;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [6:0] m_req;
  logic       m_valid;
  logic [2:0] m_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  swi_pirq_top u0 (.*);

  function automatic logic [2:0] hi_level(input logic [6:0] r);
    logic [2:0] l = 3'd0;
    for (int i = 0; i < 7; i++) if (r[i]) l = 3'(i + 1);
    return l;
  endfunction

  function automatic logic [15:0] exp_word(input logic [6:0] r);
    logic [2:0] l = hi_level(r);
    return {r, 1'b0, l, 1'b0, l, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2 request bits", 32'(rd_data[15:9]), 32'(m_req));
    check("R3 level fields", 32'({rd_data[7:5], rd_data[3:1]}), 32'({hi_level(m_req), hi_level(m_req)}));
    check("R4 gap bits", 32'({rd_data[8], rd_data[4], rd_data[0]}), 32'd0);
    check("R5 irq_valid", 32'(irq_valid), 32'(m_valid));
    if (m_valid) check("R6 irq_level", 32'(irq_level), 32'(m_lvl));
    check("R6 irq_vector", 32'(irq_vector), 32'o240);
  endtask

  // Drive at negedge, advance one edge, update model, sample 1 time unit later.
  task automatic step(input logic we, input logic [15:0] wd, input logic [2:0] pri, input logic ack);
    wr_en = we; wr_data = wd; cur_pri = pri; irq_ack = ack;
    @(posedge clk);
    if (rst_n) begin
      logic nv;
      nv = (hi_level(m_req) > pri) && !(m_valid && ack);
      m_lvl = hi_level(m_req);
      m_valid = nv;
      if (we) m_req = wd[15:9];
    end
    #1;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_data = '0; cur_pri = '0; irq_ack = 0;
    m_req = '0; m_valid = 0; m_lvl = '0;
    // preload garbage then reset on top of it (R1)
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 16'hFE00, 3'd0, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    m_req = '0; m_valid = 0; m_lvl = '0;
    check("R1 reset read", 32'(rd_data), 32'd0);
    check("R1 reset irq", 32'(irq_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // level 1 at priority 0: offered; at priority 1: not (R5 strict)
    step(1'b1, 16'h0200, 3'd0, 1'b0);
    step(1'b0, 16'h0000, 3'd0, 1'b0);
    check("R5 level1 above pri0", 32'(irq_valid), 32'd1);
    step(1'b0, 16'h0000, 3'd1, 1'b0);
    check("R5 level1 equal pri1", 32'(irq_valid), 32'd0);

    // level 7 with priority 7 then 6
    step(1'b1, 16'h8000, 3'd7, 1'b0);
    step(1'b0, 16'h0000, 3'd7, 1'b0);
    check("R5 level7 equal pri7", 32'(irq_valid), 32'd0);
    step(1'b0, 16'h0000, 3'd6, 1'b0);
    check("R6 level7 offered", 32'(irq_level), 32'd7);

    // multiple posts plus low-byte noise (R3, R4)
    step(1'b1, 16'b0101_0010_1111_1111, 3'd0, 1'b0);
    check("R4 noise ignored", 32'(rd_data), 32'(exp_word(7'b0101001)));
    check("R3 highest of several", 32'(rd_data[7:5]), 32'd6);

    // clear highest, next lower remains (R8)
    step(1'b1, 16'b0001_0010_0000_0000, 3'd0, 1'b0);
    check("R8 drop to next level", 32'(rd_data[3:1]), 32'd4);

    // ack: gap and bits kept (R7)
    step(1'b0, 16'h0000, 3'd0, 1'b0);
    check("R7 offered before ack", 32'(irq_valid), 32'd1);
    step(1'b0, 16'h0000, 3'd0, 1'b1);
    check("R7 gap after ack", 32'(irq_valid), 32'd0);
    check("R7 bits kept", 32'(rd_data[15:9]), 32'b0001001);
    step(1'b0, 16'h0000, 3'd0, 1'b0);
    check("R7 reoffer while posted", 32'(irq_valid), 32'd1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic we = ($urandom % 4) == 0;
      step(we, 16'($urandom), 3'($urandom), ($urandom % 3) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule